// File: doc/BRIEF.md
# Signed-Bit Packed Accumulate Unit

This block is an arithmetic extension for a processor datapath. It updates a packed accumulator word by adding or subtracting a packed operand word, lane by lane, where the direction for each lane comes from one bit of a small side register. Each bit of that register stands for +1 or −1. The update D = D + b·C therefore needs no multiplier, only one adder/subtractor per lane. This is the inner step of correlation and multiuser-detection kernels.

The side register is written by its own load strobe and keeps its value until the next write, so one sign pattern can serve many issues. An issue strobe computes the new accumulator from the presented operand words and the held sign pattern. The result is registered, and a one-cycle done pulse marks it. A mode input chooses between wrap-around and saturating lane arithmetic.

Top module: `bitsign_acc`

## Requirements
- R1: After reset the result output is all zeros, done is low and the held sign register is all zeros, so an issue before any load subtracts in every lane.
- R2: The words are split into LANES signed lanes of LANE_W bits; lane i occupies bits [LANE_W*i+LANE_W-1 : LANE_W*i]. When sign bit i is 1, lane i of the result is d lane plus c lane.
- R3: When sign bit i is 0, lane i of the result is d lane minus c lane.
- R4: With sat_mode = 0, lane results wrap modulo 2^LANE_W (for 8-bit lanes, 127 + 1 gives −128).
- R5: With sat_mode = 1, lane results clamp to the signed range (−128..127 for 8-bit lanes).
- R6: The result appears on d_out at the clock edge after the issue cycle, and done is high for exactly that one cycle per issue.
- R7: While issue is low, d_out keeps its value whatever c_in, d_in and sat_mode do.
- R8: b_load captures b_in at the clock edge, and the value holds until the next load. An issue in the same cycle as a load uses the value held before that load.
- R9: No carry or borrow passes between lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| c_in | input | LANES*LANE_W | Packed operand word C |
| d_in | input | LANES*LANE_W | Packed accumulator input D |
| b_in | input | LANES | New sign pattern |
| b_load | input | 1 | Writes b_in into the sign register |
| issue | input | 1 | Starts one accumulate operation |
| sat_mode | input | 1 | 1 = saturating lanes, 0 = wrapping lanes |
| d_out | output | LANES*LANE_W | Registered updated accumulator |
| done | output | 1 | One-cycle pulse when d_out is updated |

## Verification
The bench builds the block with its default eight lanes of eight bits. This exposes the lane boundaries at every eighth bit and puts the extreme values −128 and 127 within reach of directed stimulus. A behavioural model with integer lane arithmetic runs beside the block and is compared on every clock. The bench drives directed corner words for wrap, clamp and lane isolation, then random operands with interleaved loads, issues and mode changes. The random phase also covers loads that coincide with an issue.

// File: rtl/bitsign_pkg.sv
package bitsign_pkg;
  typedef enum logic {
    LANE_WRAP = 1'b0,
    LANE_SAT  = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/bitsign_rst_sync.sv
module bitsign_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/bitsign_breg.sv
module bitsign_breg #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] b_in,
  input  logic             b_load,
  output logic [LANES-1:0] b_q
);
  logic [LANES-1:0] b_nxt;

  always_comb b_nxt = b_load ? b_in : b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_q <= '0;
    else        b_q <= b_nxt;
  end
endmodule

// File: rtl/bitsign_lane.sv
module bitsign_lane
  import bitsign_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] d_l,
  input  logic [LANE_W-1:0] c_l,
  input  logic              add_l,
  input  lane_mode_e        mode,
  output logic [LANE_W-1:0] res_l
);
  localparam int EXT_W = LANE_W + 1;
  localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [EXT_W-1:0] d_ext, c_ext, sum_ext;
  logic             ovf;

  always_comb begin
    d_ext   = {d_l[LANE_W-1], d_l};
    c_ext   = {c_l[LANE_W-1], c_l};
    sum_ext = add_l ? (d_ext + c_ext) : (d_ext - c_ext);
    ovf     = sum_ext[EXT_W-1] ^ sum_ext[LANE_W-1];
    if (mode == LANE_SAT && ovf)
      res_l = sum_ext[EXT_W-1] ? NEG_MIN : POS_MAX;
    else
      res_l = sum_ext[LANE_W-1:0];
  end
endmodule

// File: rtl/bitsign_acc.sv
module bitsign_acc
  import bitsign_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] c_in,
  input  logic [LANES*LANE_W-1:0] d_in,
  input  logic [LANES-1:0]        b_in,
  input  logic                    b_load,
  input  logic                    issue,
  input  logic                    sat_mode,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    done
);
  localparam int WORD_W = LANES * LANE_W;

  logic              rst_n_s;
  logic [LANES-1:0]  b_q;
  logic [WORD_W-1:0] lane_res;
  logic [WORD_W-1:0] d_q, d_nxt;
  logic              done_q, done_nxt;
  lane_mode_e        mode;

  assign mode = lane_mode_e'(sat_mode);

  bitsign_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  bitsign_breg #(.LANES(LANES)) u_breg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .b_in   (b_in),
    .b_load (b_load),
    .b_q    (b_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bitsign_lane #(.LANE_W(LANE_W)) u_lane (
      .d_l   (d_in[i*LANE_W +: LANE_W]),
      .c_l   (c_in[i*LANE_W +: LANE_W]),
      .add_l (b_q[i]),
      .mode  (mode),
      .res_l (lane_res[i*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    d_nxt    = issue ? lane_res : d_q;
    done_nxt = issue;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      d_q    <= '0;
      done_q <= 1'b0;
    end else begin
      d_q    <= d_nxt;
      done_q <= done_nxt;
    end
  end

  assign d_out = d_q;
  assign done  = done_q;
endmodule

// File: rtl/bitsign_acc_chk.sv
module bitsign_acc_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n_s,
  input logic [LANES*LANE_W-1:0] c_in,
  input logic [LANES*LANE_W-1:0] d_in,
  input logic [LANES-1:0]        b_in,
  input logic                    b_load,
  input logic                    issue,
  input logic                    sat_mode,
  input logic [LANES-1:0]        b_q,
  input logic [LANES*LANE_W-1:0] d_out,
  input logic                    done
);
  // R6: a done pulse follows each issue by one cycle
  a_r6_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue |=> done);
  a_r6_done_needs_issue: assert property (@(posedge clk) disable iff (!rst_n_s)
    !issue |=> !done);
  // R7: result is held without an issue
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !issue |=> $stable(d_out));
  // R8: sign register capture and retention
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n_s)
    b_load |=> (b_q == $past(b_in)));
  a_r8_retain: assert property (@(posedge clk) disable iff (!rst_n_s)
    !b_load |=> $stable(b_q));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R5: saturating add of a non-negative operand never lowers the lane
    a_r5_sat_no_wrap: assert property (@(posedge clk) disable iff (!rst_n_s)
      (issue && sat_mode && b_q[i] && !c_in[i*LANE_W+LANE_W-1]) |=>
      ($signed(d_out[i*LANE_W +: LANE_W]) >= $signed($past(d_in[i*LANE_W +: LANE_W]))));
  end
endmodule

bind bitsign_acc bitsign_acc_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .c_in     (c_in),
  .d_in     (d_in),
  .b_in     (b_in),
  .b_load   (b_load),
  .issue    (issue),
  .sat_mode (sat_mode),
  .b_q      (b_q),
  .d_out    (d_out),
  .done     (done)
);

// File: tb/tb_bitsign_acc.sv
`timescale 1ns/1ps
module tb_bitsign_acc;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WORD_W-1:0] c_in = '0, d_in = '0;
  logic [LANES-1:0]  b_in = '0;
  logic              b_load = 1'b0, issue = 1'b0, sat_mode = 1'b0;
  logic [WORD_W-1:0] d_out;
  logic              done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_en = 0;
  string cur_req = "R1";

  logic [WORD_W-1:0] exp_d = '0;
  logic              exp_done = 1'b0;
  logic [LANES-1:0]  b_ref = '0;

  always #10 clk = ~clk;

  bitsign_acc #(.LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .c_in(c_in), .d_in(d_in), .b_in(b_in),
    .b_load(b_load), .issue(issue), .sat_mode(sat_mode),
    .d_out(d_out), .done(done)
  );

  function automatic logic [WORD_W-1:0] ref_op(input logic [WORD_W-1:0] d,
      input logic [WORD_W-1:0] c, input logic [LANES-1:0] b, input logic sat);
    logic [WORD_W-1:0] r;
    int lo, hi;
    lo = -(1 << (LANE_W-1));
    hi = (1 << (LANE_W-1)) - 1;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      int dv, cv, s;
      dv = $signed(d[i*LANE_W +: LANE_W]);
      cv = $signed(c[i*LANE_W +: LANE_W]);
      s  = b[i] ? dv + cv : dv - cv;
      if (sat) begin
        if (s > hi) s = hi;
        if (s < lo) s = lo;
      end
      r[i*LANE_W +: LANE_W] = s[LANE_W-1:0];
    end
    return r;
  endfunction

  // behavioural reference, updated on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_d <= '0; exp_done <= 1'b0; b_ref <= '0;
    end else begin
      if (issue) exp_d <= ref_op(d_in, c_in, b_ref, sat_mode);
      exp_done <= issue;
      if (b_load) b_ref <= b_in;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      checks++;
      if (d_out !== exp_d || done !== exp_done) begin
        errors++;
        $display("FAIL %s: d_out=%h done=%b expected d_out=%h done=%b",
                 cur_req, d_out, done, exp_d, exp_done);
      end
    end
  end

  task automatic drive(input logic [WORD_W-1:0] c, input logic [WORD_W-1:0] d,
      input logic [LANES-1:0] b, input logic bl, input logic is, input logic sm);
    @(posedge clk); #2;
    c_in = c; d_in = d; b_in = b; b_load = bl; issue = is; sat_mode = sm;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(c_in ^ 64'hA5A5_5A5A_0F0F_F0F0, ~d_in, b_in, 1'b0, 1'b0, ~sat_mode);
  endtask

  initial begin
    #200000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cmp_en = 1;
    // R1: reset state, then issue with untouched sign register subtracts
    cur_req = "R1";
    idle(2);
    drive(64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, '0, 1'b0, 1'b1, 1'b0);
    idle(2);
    // R2: all lanes add
    cur_req = "R2";
    drive('0, '0, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(64'h0102_0304_0506_0708, 64'h1020_3040_F0E0_D0C0, 8'h00, 1'b0, 1'b1, 1'b0);
    idle(1);
    // R3: mixed signs, bit i controls lane i
    cur_req = "R3";
    drive('0, '0, 8'b1010_0101, 1'b1, 1'b0, 1'b0);
    drive(64'h0505_0505_0505_0505, 64'h2020_2020_2020_2020, 8'h00, 1'b0, 1'b1, 1'b0);
    // R4: wrap corners 127+1, -128-1
    cur_req = "R4";
    drive('0, '0, 8'h0F, 1'b1, 1'b0, 1'b0);
    drive(64'h0101_0101_0101_0101, 64'h8080_8080_7F7F_7F7F, 8'h00, 1'b0, 1'b1, 1'b0);
    // R5: same corners saturate, plus -128 - (-128)
    cur_req = "R5";
    drive(64'h0101_0101_0101_0101, 64'h8080_8080_7F7F_7F7F, 8'h00, 1'b0, 1'b1, 1'b1);
    drive(64'h8080_8080_8080_8080, 64'h7F7F_8080_7F7F_8080, 8'h00, 1'b0, 1'b1, 1'b1);
    // R6: back-to-back issues then gap
    cur_req = "R6";
    drive(64'h1111_1111_1111_1111, 64'h0, 8'h00, 1'b0, 1'b1, 1'b0);
    drive(64'h2222_2222_2222_2222, 64'h0, 8'h00, 1'b0, 1'b1, 1'b0);
    idle(3);
    // R7: operands toggle with no issue, output must hold
    cur_req = "R7";
    idle(6);
    // R8: load and issue together use the old pattern
    cur_req = "R8";
    drive(64'h0303_0303_0303_0303, 64'h1010_1010_1010_1010, 8'hF0, 1'b1, 1'b1, 1'b0);
    drive(64'h0303_0303_0303_0303, 64'h1010_1010_1010_1010, 8'h00, 1'b0, 1'b1, 1'b0);
    idle(1);
    // R9: lane 0 wraps without touching lane 1
    cur_req = "R9";
    drive('0, '0, 8'hFF, 1'b1, 1'b0, 1'b0);
    drive(64'h0000_0000_0000_0001, 64'h0000_0000_0000_00FF, 8'h00, 1'b0, 1'b1, 1'b0);
    drive('0, '0, 8'h00, 1'b1, 1'b0, 1'b0);
    drive(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 8'h00, 1'b0, 1'b1, 1'b0);
    // random mix across all requirements
    cur_req = "R2/R3/R4/R5/R8";
    for (int n = 0; n < 400; n++)
      drive({$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
    idle(2);
    cmp_en = 0;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule